// File: doc/BRIEF.md
# Fixed-Length LAPD Message Transmitter with CRC-16

This block sends a single data-link message, framed HDLC style, as a serial bit stream. A host loads the message bytes into an internal byte memory through a simple write port. It picks one of two message lengths, 76 or 82 bytes, and pulses a start input. The block then sends an opening flag, the message bytes, a 16-bit frame check sequence and a closing flag. Zero bits are inserted wherever the payload would otherwise contain a run of ones long enough to look like a flag.

The serializer moves forward only when the surrounding framer requests a bit. Each accepted request produces exactly one new output bit. When no message is being sent, the line carries a continuous stream of flags. When the closing flag is complete, the block drops its busy indication and pulses a completion interrupt for one cycle. Placing the bits into particular overhead positions is left to the framer.

Top module: `lapd_tx`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_bit`, `busy` and `done_irq` are 0.
- R2: When no message is in progress, each accepted request sends the next bit of the flag 0x7E, least-significant bit first (0,1,1,1,1,1,1,0), and the flags repeat without gaps.
- R3: `tx_bit` is registered. It takes its new value on the clock edge that samples `bit_req` high and holds it on every cycle without a request.
- R4: A `start` pulse while idle raises `busy` on the next cycle. The message begins at the next flag boundary, defined as the point where the next accepted bit would be bit 0 of a flag, and its first eight bits are an opening flag.
- R5: In the message and check-sequence bits, a 0 is inserted after every five consecutive ones, and that includes the point just before the closing flag. Opening and closing flags are never stuffed.
- R6: Message bytes are read from addresses 0 upward and sent least-significant bit first. `len_sel`=0 selects 76 bytes and `len_sel`=1 selects 82 bytes, and the value is sampled at the accepted `start`.
- R7: The check sequence uses x^16+x^12+x^5+1 with register preset 0xFFFF, computed over the message bits in send order. The ones-complement of the register is sent, starting with the x^15 coefficient.
- R8: A closing flag follows the check sequence. On the cycle after its last bit is accepted, `busy` is 0 and `done_irq` is 1 for exactly one cycle, and idle flags resume at bit 0.
- R9: A `start` pulse while `busy` is 1 is ignored. The message in progress and its length are unchanged, and no second message follows.
- R10: Writes to the message memory while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Message byte write strobe |
| wr_addr | input | 7 | Message byte address (log2 of DEPTH bits) |
| wr_data | input | 8 | Message byte value |
| len_sel | input | 1 | Length select: 0 = 76 bytes, 1 = 82 bytes |
| start | input | 1 | Start pulse |
| bit_req | input | 1 | Framer request for one output bit |
| tx_bit | output | 1 | Serial output bit |
| busy | output | 1 | Message pending or in transmission |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
Most internal faults appear on the serial line within a few requested bits:
- A wrong byte counter or length register shifts the closing flag, so the very next expected bit differs from the one produced.
- A wrong stuffing count or check-sequence register corrupts the bits up to and including the closing flag.
- A flag bit counter that is out of phase breaks the idle pattern within eight requests, because the bench tracks idle flag phase across messages.

Busy and interrupt are compared on every requested bit, so a premature or missing completion is seen on the exact bit where it occurs.

// File: rtl/lapd_pkg.sv
package lapd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE
  } tx_state_t;

  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
  localparam int          STUFF_RUN = 5;
endpackage

// File: rtl/lapd_msg_ram.sv
module lapd_msg_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read: maps to one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lapd_crc_step.sv
module lapd_crc_step #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic [W-1:0] crc_in,
  input  logic         din,
  output logic [W-1:0] crc_out
);
  logic fb;

  always_comb begin
    fb      = din ^ crc_in[W-1];
    crc_out = {crc_in[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/lapd_tx.sv
module lapd_tx
  import lapd_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int LEN_SHORT = 76,
  parameter int LEN_LONG  = 82
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     len_sel,
  input  logic                     start,
  input  logic                     bit_req,
  output logic                     tx_bit,
  output logic                     busy,
  output logic                     done_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(STUFF_RUN + 1);

  tx_state_t      st;
  logic [2:0]     bc;
  logic [3:0]     fc;
  logic [AW-1:0]  nidx;
  logic [AW-1:0]  len_q;
  logic [7:0]     sh;
  logic [7:0]     rd_q;
  logic [15:0]    crc;
  logic [15:0]    crc_nx;
  logic [CW-1:0]  ones;
  logic           stuff;

  // message memory, read address always points at the next byte to load
  lapd_msg_ram #(.DEPTH(DEPTH), .DW(8)) u_ram (
    .clk   (clk),
    .we    (wr_en & ~busy),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (nidx),
    .rdata (rd_q)
  );

  lapd_crc_step #(.W(16), .POLY(CRC_POLY)) u_crc (
    .crc_in  (crc),
    .din     (sh[0]),
    .crc_out (crc_nx)
  );

  always_comb begin
    stuff = (ones == CW'(STUFF_RUN)) &&
            ((st == ST_DATA) || (st == ST_FCS) || ((st == ST_CLOSE) && (bc == 3'd0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bc       <= '0;
      fc       <= '0;
      nidx     <= '0;
      len_q    <= '0;
      sh       <= '0;
      crc      <= CRC_INIT;
      ones     <= '0;
      tx_bit   <= 1'b0;
      busy     <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        len_q <= len_sel ? AW'(LEN_LONG) : AW'(LEN_SHORT);
      end
      if (bit_req) begin
        if (stuff) begin
          tx_bit <= 1'b0;
          ones   <= '0;
        end else begin
          unique case (st)
            ST_IDLE: begin
              tx_bit <= FLAG_BYTE[bc];
              bc     <= bc + 3'd1;
              if (busy && bc == 3'd0) st <= ST_OPEN;
            end
            ST_OPEN: begin
              tx_bit <= FLAG_BYTE[bc];
              bc     <= bc + 3'd1;
              if (bc == 3'd7) begin
                st   <= ST_DATA;
                sh   <= rd_q;
                nidx <= nidx + 1'b1;
                crc  <= CRC_INIT;
                ones <= '0;
              end
            end
            ST_DATA: begin
              tx_bit <= sh[0];
              sh     <= sh >> 1;
              crc    <= crc_nx;
              ones   <= sh[0] ? ones + 1'b1 : '0;
              bc     <= bc + 3'd1;
              if (bc == 3'd7) begin
                if (nidx == len_q) begin
                  st <= ST_FCS;
                  fc <= '0;
                end else begin
                  sh   <= rd_q;
                  nidx <= nidx + 1'b1;
                end
              end
            end
            ST_FCS: begin
              tx_bit <= ~crc[15];
              crc    <= {crc[14:0], 1'b0};
              ones   <= ~crc[15] ? ones + 1'b1 : '0;
              fc     <= fc + 4'd1;
              if (fc == 4'd15) begin
                st <= ST_CLOSE;
                bc <= '0;
              end
            end
            ST_CLOSE: begin
              tx_bit <= FLAG_BYTE[bc];
              bc     <= bc + 3'd1;
              if (bc == 3'd7) begin
                st       <= ST_IDLE;
                busy     <= 1'b0;
                done_irq <= 1'b1;
                nidx     <= '0;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/lapd_tx_chk.sv
module lapd_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_req,
  input logic start,
  input logic tx_bit,
  input logic busy,
  input logic done_irq
);
  logic       req_d;
  logic [3:0] run;

  // length of the current run of ones on the line, in accepted bits
  always_ff @(posedge clk) begin
    if (rst) begin
      req_d <= 1'b0;
      run   <= '0;
    end else begin
      req_d <= bit_req;
      if (req_d) run <= tx_bit ? ((run == 4'd15) ? run : run + 4'd1) : 4'd0;
    end
  end

  a_r3_hold_without_req: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bit_req)) |-> $stable(tx_bit));

  a_r4_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r5_run_limit: assert property (@(posedge clk) disable iff (rst)
    run <= 4'd6);

  a_r8_irq_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (!busy && $past(busy)));

  a_r8_busy_falls_with_irq: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_irq);

  a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
endmodule

bind lapd_tx lapd_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_req  (bit_req),
  .start    (start),
  .tx_bit   (tx_bit),
  .busy     (busy),
  .done_irq (done_irq)
);

// File: tb/sim_lapd_tx.sv
`timescale 1ns/1ps
module sim_lapd_tx;
  localparam int DEPTH = 128;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          len_sel = 1'b0;
  logic          start = 1'b0;
  logic          bit_req = 1'b0;
  logic          tx_bit, busy, done_irq;

  always #2 clk = ~clk;

  lapd_tx u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .len_sel(len_sel), .start(start), .bit_req(bit_req),
    .tx_bit(tx_bit), .busy(busy), .done_irq(done_irq)
  );

  logic [7:0] mem_m [DEPTH];
  bit         q[$];
  int         ph = 0;
  bit         active = 0;
  bit         exp_busy = 0;
  int         st_ones = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 0;
  localparam logic [7:0] FLAGB = 8'h7E;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard driver side: expected payload bit with stuffing (R5)
  task automatic push_stuffed(bit b);
    q.push_back(b);
    if (b) begin
      st_ones++;
      if (st_ones == 5) begin
        q.push_back(1'b0);
        st_ones = 0;
      end
    end else st_ones = 0;
  endtask

  task automatic build(bit ls);
    int          len = ls ? 82 : 76;          // R6 length select
    logic [15:0] c = 16'hFFFF;
    bit          fb;
    for (int i = 0; i < 8; i++) q.push_back(FLAGB[i]);
    st_ones = 0;
    for (int k = 0; k < len; k++) begin
      for (int i = 0; i < 8; i++) begin
        push_stuffed(mem_m[k][i]);
        fb = mem_m[k][i] ^ c[15];
        c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);   // R7
      end
    end
    for (int j = 15; j >= 0; j--) push_stuffed(~c[j]);
    for (int i = 0; i < 8; i++) q.push_back(FLAGB[i]);
  endtask

  // monitor side: one accepted request, then compare
  task automatic step();
    bit e;
    bit done;
    bit msg;
    bit_req = 1'b1;
    @(negedge clk);
    bit_req = 1'b0;
    done = 0;
    msg  = 0;
    if (active || (q.size() > 0 && ph == 0)) begin
      active = 1;
      msg    = 1;
      e      = q.pop_front();
      if (q.size() == 0) begin
        active   = 0;
        ph       = 0;
        done     = 1;
        exp_busy = 0;
      end
    end else begin
      e  = FLAGB[ph];
      ph = (ph + 1) % 8;
    end
    if (msg) chk("R7 message stream bit", tx_bit, e);
    else     chk("R2 idle flag bit", tx_bit, e);
    chk("R8 busy level", busy, exp_busy);
    chk("R8 done_irq pulse", done_irq, done);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      step();
      repeat (i % 3) @(negedge clk);
    end
  endtask

  task automatic finish_msg();
    int guard = 0;
    while (exp_busy && guard < 4000) begin
      step();
      if (guard % 7 == 3) @(negedge clk);
      guard++;
    end
    chk("R8 message completed", exp_busy, 0);
  endtask

  task automatic do_start(bit ls);
    bit was = exp_busy;
    start   = 1'b1;
    len_sel = ls;
    @(negedge clk);
    start = 1'b0;
    if (!was) begin
      build(ls);
      exp_busy = 1;
      chk("R4 busy after start", busy, 1);
    end else chk("R9 busy held on ignored start", busy, 1);
  endtask

  task automatic do_write(int a, logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!exp_busy) mem_m[a] = d;   // R10 writes while busy dropped
  endtask

  initial begin
    logic v;
    repeat (3) @(negedge clk);
    chk("R1 reset tx_bit", tx_bit, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done_irq", done_irq, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset busy", busy, 0);
    chk("R1 post-reset tx_bit", tx_bit, 0);

    run(20);                                   // R2 idle flags
    v = tx_bit;
    repeat (6) @(negedge clk);
    chk("R3 hold without request", tx_bit, v);

    for (int i = 0; i < 82; i++) begin
      logic [7:0] d = 8'((i * 29 + 3) & 255);
      if (i >= 10 && i <= 12) d = 8'hFF;
      if (i == 40) d = 8'h3E;
      if (i == 41) d = 8'h1F;
      do_write(i, d);
    end

    do_start(1'b1);                            // R6 long message, mid-flag start (R4)
    run(5);
    do_start(1'b0);                            // R9 ignored
    do_write(70, 8'h00);                       // R10 ignored
    finish_msg();
    run(13);
    chk("R9 no second message", busy, 0);
    run(3);

    do_start(1'b0);                            // R6 short message at flag boundary
    finish_msg();
    run(9);

    for (int i = 0; i < 82; i++) do_write(i, 8'hFF);
    do_start(1'b0);                            // R5 heavy stuffing
    finish_msg();
    run(10);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule